// File: doc/BRIEF.md
# Instruction Prefetch Queue with Bus Arbiter

This block runs ahead of the instruction decoder. It keeps a ring of upcoming code bytes filled. Instruction bytes and their immediate and displacement bytes are all taken from the head of this ring. The block fetches one aligned 32-bit word at a time from consecutive code addresses. It does so through a bus port that it shares with data transfers coming from execution.

Data transfers always own the bus. A code fetch is raised only in a cycle with no data request, so with zero-wait memory prefetch never delays a data access. A redirect, such as a taken branch, loads a new fetch address. It empties the ring and discards any code word still in flight. When the target is not word aligned, the bytes of the first word below the target are dropped.

The decoder sees the next bytes at the head, a count of valid bytes and an empty flag. It returns a consume count each cycle.

Top module: `code_prefetch_queue`

## Requirements
- R1: After reset the ring is empty: `dec_avail_o` is 0, `dec_empty_o` is 1, and the first code request targets address 0.
- R2: Code requests carry word-aligned addresses (bits 1:0 zero). Each accepted code request advances the next request address by 4.
- R3: While `dx_req_i` is high, the bus carries the data address with `bus_code_o` low, no code request is accepted, and `dx_gnt_o` equals `bus_ready_i`.
- R4: A code request is raised only when no code word is outstanding and the ring has at least 4 free bytes.
- R5: Lane k of `dec_bytes_o` (bits 8k+7:8k) holds the byte k places after the head. Lanes at or beyond `dec_avail_o` read as zero. A returned word enters the ring lowest byte (bits 7:0, lowest address) first.
- R6: A consume count removes that many bytes from the head on the next edge. A count larger than `dec_avail_o` or larger than the lane count (4) is ignored as a whole.
- R7: A redirect empties the ring on the next edge. A code word outstanding at that time is discarded when it returns. The next code request targets the new address rounded down to a word.
- R8: For a redirect target with low bits s, only bytes s..3 of the first returned word enter the ring.
- R9: `dec_empty_o` is 1 exactly when no byte is held, and all lanes are then zero.
- R10: The ring never holds more than 16 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| redir_i | input | 1 | Redirect fetch stream, flush ring |
| redir_addr_i | input | 32 | New fetch byte address |
| dx_req_i | input | 1 | Data transfer request from execution |
| dx_addr_i | input | 32 | Data transfer address |
| dx_gnt_o | output | 1 | Data transfer accepted by bus |
| bus_valid_o | output | 1 | Bus request valid |
| bus_code_o | output | 1 | Current bus request is a code fetch |
| bus_addr_o | output | 32 | Bus request address |
| bus_ready_i | input | 1 | Bus accepts request |
| fetch_rvalid_i | input | 1 | Code word returned |
| fetch_rdata_i | input | 32 | Returned code word |
| dec_bytes_o | output | 32 | Four head bytes, lane 0 oldest |
| dec_avail_o | output | 5 | Valid bytes held |
| dec_empty_o | output | 1 | Nothing held, decode must stall |
| dec_consume_i | input | 3 | Bytes taken by decoder this cycle |

## Verification
A corrupted head or write pointer shows at once as a wrong byte in lane 0, one cycle after a consume or a pushed word. A count that drifts shows as a wrong `dec_avail_o`, or as a code request that appears while the ring lacks room. A stuck in-flight or discard flag shows within two cycles of the returned word. Either no new code request appears, or stale bytes from before the redirect fill the ring. The bench therefore freezes the bus to walk consume patterns against an exact count. It then checks the bytes that arrive right after each redirect.

// File: rtl/cpq_pkg.sv
package cpq_pkg;
  typedef logic [7:0] byte_t;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/cpq_arb.sv
module cpq_arb #(
  parameter int unsigned AW = 32
) (
  input  logic          dx_req_i,
  input  logic [AW-1:0] dx_addr_i,
  input  logic          pf_want_i,
  input  logic [AW-1:0] pf_addr_i,
  input  logic          bus_ready_i,
  output logic          bus_valid_o,
  output logic          bus_code_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          dx_gnt_o,
  output logic          pf_issue_o
);
  // fixed priority: data transfers first, prefetch only on idle cycles
  always_comb begin
    bus_valid_o = dx_req_i | pf_want_i;
    bus_code_o  = ~dx_req_i & pf_want_i;
    bus_addr_o  = dx_req_i ? dx_addr_i : pf_addr_i;
    dx_gnt_o    = dx_req_i & bus_ready_i;
    pf_issue_o  = bus_code_o & bus_ready_i;
  end
endmodule

// File: rtl/cpq_fetch.sv
module cpq_fetch #(
  parameter int unsigned AW         = 32,
  parameter int unsigned WB         = 4,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  localparam int unsigned SKW = $clog2(WB),
  localparam int unsigned PNW = $clog2(WB+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             redir_i,
  input  logic [AW-1:0]    redir_addr_i,
  input  logic             room_i,
  input  logic             pf_issue_i,
  input  logic             rvalid_i,
  input  logic [WB*8-1:0]  rdata_i,
  output logic             pf_want_o,
  output logic [AW-1:0]    pf_addr_o,
  output logic [PNW-1:0]   push_n_o,
  output logic [WB*8-1:0]  push_data_o
);
  logic [AW-1:0]  fetch_addr_q;
  logic           inflight_q, drop_q;
  logic [SKW-1:0] skip_q;
  logic           resp;

  assign resp      = rvalid_i & inflight_q;
  assign pf_want_o = ~inflight_q & room_i & ~redir_i;
  assign pf_addr_o = {fetch_addr_q[AW-1:SKW], {SKW{1'b0}}};

  always_comb begin
    push_n_o    = '0;
    push_data_o = rdata_i >> (skip_q * 8);
    if (resp && !drop_q && !redir_i) push_n_o = PNW'(WB) - PNW'(skip_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_addr_q <= RESET_ADDR;
      inflight_q   <= 1'b0;
      drop_q       <= 1'b0;
      skip_q       <= '0;
    end else if (redir_i) begin
      fetch_addr_q <= redir_addr_i;
      drop_q       <= inflight_q & ~rvalid_i;
      if (rvalid_i) inflight_q <= 1'b0;
    end else begin
      if (pf_issue_i) begin
        inflight_q   <= 1'b1;
        skip_q       <= fetch_addr_q[SKW-1:0];
        fetch_addr_q <= pf_addr_o + AW'(WB);
      end
      if (resp) begin
        inflight_q <= 1'b0;
        drop_q     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cpq_buf.sv
module cpq_buf
  import cpq_pkg::*;
#(
  parameter int unsigned QB    = 16,
  parameter int unsigned WB    = 4,
  parameter int unsigned RB    = 4,
  localparam int unsigned CW   = $clog2(QB+1),
  localparam int unsigned PW   = $clog2(QB),
  localparam int unsigned PNW  = $clog2(WB+1),
  localparam int unsigned CNSW = $clog2(RB)+1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [PNW-1:0]    push_n_i,
  input  logic [WB*8-1:0]   push_data_i,
  input  logic [CNSW-1:0]   consume_i,
  output logic [RB*8-1:0]   rd_bytes_o,
  output logic [CW-1:0]     avail_o,
  output logic              empty_o,
  output logic              room_o
);
  byte_t          mem [QB];
  logic [PW-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CW-1:0]  count_q;
  logic [CNSW-1:0] pop_n;
  logic           pop_ok;

  assign pop_ok  = (CW'(consume_i) <= count_q) && (consume_i <= CNSW'(RB));
  assign pop_n   = pop_ok ? consume_i : '0;
  assign avail_o = count_q;
  assign empty_o = (count_q == '0);
  assign room_o  = (CW'(QB) - count_q) >= CW'(WB);

  for (genvar k = 0; k < RB; k++) begin : g_lane
    assign rd_bytes_o[k*BYTE_W +: BYTE_W] =
      (CW'(k) < count_q) ? mem[rd_ptr_q + PW'(k)] : '0;
  end

  always_ff @(posedge clk_i) begin
    if (!flush_i) begin
      for (int i = 0; i < WB; i++) begin
        if (PNW'(i) < push_n_i) mem[wr_ptr_q + PW'(i)] <= push_data_i[i*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_q + PW'(pop_n);
      wr_ptr_q <= wr_ptr_q + PW'(push_n_i);
      count_q  <= count_q + CW'(push_n_i) - CW'(pop_n);
    end
  end
endmodule

// File: rtl/code_prefetch_queue.sv
module code_prefetch_queue #(
  parameter int unsigned AW      = 32,
  parameter int unsigned QBYTES  = 16,
  parameter int unsigned WB      = 4,
  parameter int unsigned RB      = 4,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         redir_i,
  input  logic [AW-1:0]                redir_addr_i,
  input  logic                         dx_req_i,
  input  logic [AW-1:0]                dx_addr_i,
  output logic                         dx_gnt_o,
  output logic                         bus_valid_o,
  output logic                         bus_code_o,
  output logic [AW-1:0]                bus_addr_o,
  input  logic                         bus_ready_i,
  input  logic                         fetch_rvalid_i,
  input  logic [WB*8-1:0]              fetch_rdata_i,
  output logic [RB*8-1:0]              dec_bytes_o,
  output logic [$clog2(QBYTES+1)-1:0]  dec_avail_o,
  output logic                         dec_empty_o,
  input  logic [$clog2(RB):0]          dec_consume_i
);
  localparam int unsigned PNW = $clog2(WB+1);

  logic            pf_want, pf_issue, room;
  logic [AW-1:0]   pf_addr;
  logic [PNW-1:0]  push_n;
  logic [WB*8-1:0] push_data;

  cpq_arb #(.AW(AW)) u_arb (
    .dx_req_i    (dx_req_i),
    .dx_addr_i   (dx_addr_i),
    .pf_want_i   (pf_want),
    .pf_addr_i   (pf_addr),
    .bus_ready_i (bus_ready_i),
    .bus_valid_o (bus_valid_o),
    .bus_code_o  (bus_code_o),
    .bus_addr_o  (bus_addr_o),
    .dx_gnt_o    (dx_gnt_o),
    .pf_issue_o  (pf_issue)
  );

  cpq_fetch #(.AW(AW), .WB(WB), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .redir_i      (redir_i),
    .redir_addr_i (redir_addr_i),
    .room_i       (room),
    .pf_issue_i   (pf_issue),
    .rvalid_i     (fetch_rvalid_i),
    .rdata_i      (fetch_rdata_i),
    .pf_want_o    (pf_want),
    .pf_addr_o    (pf_addr),
    .push_n_o     (push_n),
    .push_data_o  (push_data)
  );

  cpq_buf #(.QB(QBYTES), .WB(WB), .RB(RB)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (redir_i),
    .push_n_i    (push_n),
    .push_data_i (push_data),
    .consume_i   (dec_consume_i),
    .rd_bytes_o  (dec_bytes_o),
    .avail_o     (dec_avail_o),
    .empty_o     (dec_empty_o),
    .room_o      (room)
  );
endmodule

// File: rtl/cpq_checker.sv
module cpq_checker #(
  parameter int unsigned AW     = 32,
  parameter int unsigned QBYTES = 16,
  parameter int unsigned WB     = 4,
  parameter int unsigned RB     = 4,
  localparam int unsigned CW    = $clog2(QBYTES+1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  redir_i,
  input logic [AW-1:0]         redir_addr_i,
  input logic                  dx_req_i,
  input logic [AW-1:0]         dx_addr_i,
  input logic                  dx_gnt_o,
  input logic                  bus_valid_o,
  input logic                  bus_code_o,
  input logic [AW-1:0]         bus_addr_o,
  input logic                  bus_ready_i,
  input logic                  fetch_rvalid_i,
  input logic [WB*8-1:0]       fetch_rdata_i,
  input logic [RB*8-1:0]       dec_bytes_o,
  input logic [CW-1:0]         dec_avail_o,
  input logic                  dec_empty_o,
  input logic [$clog2(RB):0]   dec_consume_i
);
  p_dx_owns_bus_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dx_req_i |-> bus_valid_o && !bus_code_o && bus_addr_o == dx_addr_i);

  p_one_inflight_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_code_o && bus_ready_i) |=> !bus_code_o);

  p_room_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_code_o |-> dec_avail_o <= CW'(QBYTES - WB));

  p_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |=> dec_empty_o);

  p_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!redir_i && !fetch_rvalid_i && CW'(dec_consume_i) > dec_avail_o) |=> $stable(dec_avail_o));

  p_empty_lanes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_empty_o |-> dec_bytes_o == '0);

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_avail_o <= CW'(QBYTES));
endmodule

bind code_prefetch_queue cpq_checker #(
  .AW(AW), .QBYTES(QBYTES), .WB(WB), .RB(RB)
) u_chk (.*);

// File: tb/code_prefetch_queue_test.sv
`timescale 1ns/1ps
module code_prefetch_queue_test;
  logic        clk_i = 0, rst_ni = 0;
  logic        redir_i = 0;
  logic [31:0] redir_addr_i = '0;
  logic        dx_req_i = 0;
  logic [31:0] dx_addr_i = '0;
  logic        dx_gnt_o, bus_valid_o, bus_code_o;
  logic [31:0] bus_addr_o;
  logic        bus_ready_i = 0;
  logic        fetch_rvalid_i = 0;
  logic [31:0] fetch_rdata_i = '0;
  logic [31:0] dec_bytes_o;
  logic [4:0]  dec_avail_o;
  logic        dec_empty_o;
  logic [2:0]  dec_consume_i = '0;

  int checks = 0, errors = 0;
  logic stall = 0, pend = 0;
  logic [31:0] paddr = '0;

  always #2.5 clk_i = ~clk_i;

  code_prefetch_queue uut (.*);

  function automatic logic [7:0] mb(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] mw(input logic [31:0] a);
    return {mb(a+3), mb(a+2), mb(a+1), mb(a)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  // code bus responder: one cycle after an accepted code request
  initial forever begin
    @(negedge clk_i);
    if (bus_valid_o && bus_code_o && bus_ready_i) begin pend = 1; paddr = bus_addr_o; end
    @(posedge clk_i); #1;
    if (pend && !stall) begin
      fetch_rvalid_i = 1; fetch_rdata_i = mw(paddr); pend = 0;
    end else fetch_rvalid_i = 0;
  end

  // consume, expected avail, expected head address
  localparam int TBL [8][3] = '{
    '{3, 13, 3}, '{4, 9, 7}, '{0, 9, 7}, '{7, 9, 7},
    '{2, 7, 9},  '{4, 3, 13}, '{4, 3, 13}, '{3, 0, 16}
  };

  initial begin
    repeat (4000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act %0d exp %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    chk("R1 avail in reset", 32'(dec_avail_o), 0);
    chk("R1 empty in reset", 32'(dec_empty_o), 1);
    @(posedge clk_i); #1 rst_ni = 1; bus_ready_i = 1;
    @(negedge clk_i);
    chk("R1 first code req", 32'(bus_code_o), 1);
    chk("R1 first addr", bus_addr_o, 32'h0);

    repeat (20) @(negedge clk_i);
    chk("R10 full count", 32'(dec_avail_o), 16);
    chk("R4 no req when full", 32'(bus_code_o), 0);
    chk("R5 head lanes", dec_bytes_o, mw(0));

    @(posedge clk_i); #1 bus_ready_i = 0;
    for (int s = 0; s < 8; s++) begin
      @(posedge clk_i); #1 dec_consume_i = 3'(TBL[s][0]);
      @(posedge clk_i); #1 dec_consume_i = '0;
      @(negedge clk_i);
      chk($sformatf("R6 step %0d avail", s), 32'(dec_avail_o), 32'(TBL[s][1]));
      if (TBL[s][1] > 0)
        chk($sformatf("R5 step %0d lane0", s), 32'(dec_bytes_o[7:0]), 32'(mb(32'(TBL[s][2]))));
      else begin
        chk("R9 empty flag", 32'(dec_empty_o), 1);
        chk("R9 lanes zero", dec_bytes_o, 0);
      end
    end

    @(posedge clk_i); #1 bus_ready_i = 1; dx_req_i = 1; dx_addr_i = 32'h000A_BCD0;
    @(negedge clk_i);
    chk("R3 data addr", bus_addr_o, 32'h000A_BCD0);
    chk("R3 not code", 32'(bus_code_o), 0);
    chk("R3 grant", 32'(dx_gnt_o), 1);
    repeat (5) @(negedge clk_i);
    chk("R3 no fetch under data", 32'(dec_avail_o), 0);
    @(posedge clk_i); #1 dx_req_i = 0;
    @(negedge clk_i);
    chk("R2 seq code req", 32'(bus_code_o), 1);
    chk("R2 seq addr", bus_addr_o, 32'h10);

    @(posedge clk_i); #1 redir_i = 1; redir_addr_i = 32'h103;
    @(posedge clk_i); #1 redir_i = 0;
    @(negedge clk_i);
    chk("R7 flushed", 32'(dec_avail_o), 0);
    chk("R7 aligned target", bus_addr_o, 32'h100);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R8 skip count", 32'(dec_avail_o), 1);
    chk("R8 first byte", dec_bytes_o, {24'h0, mb(32'h103)});

    stall = 1;
    @(posedge clk_i); #1 redir_i = 1; redir_addr_i = 32'h300;
    @(posedge clk_i); #1 redir_i = 0;
    repeat (3) @(negedge clk_i);
    chk("R4 one outstanding", 32'(bus_code_o), 0);
    chk("R7 empty while stale", 32'(dec_avail_o), 0);
    stall = 0;
    @(negedge clk_i);
    chk("R7 stale word dropped", 32'(dec_avail_o), 0);
    @(negedge clk_i);
    chk("R7 new target req", bus_addr_o, 32'h300);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R7 new bytes count", 32'(dec_avail_o), 4);
    chk("R5 new bytes order", dec_bytes_o, mw(32'h300));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule